// File: doc/BRIEF.md
# Character Display Write Sequencer

This block moves single bytes from a host into a parallel character display module. The host presents an 8-bit byte together with a flag that marks the byte as a command or as character data, and raises a start request while the block reports ready. The block then owns the display interface for one transfer. It places the byte and the register-select level on the display pins and waits a programmable setup time. It then drives the enable line high for a programmable width and brings it low, which is the edge on which the display takes the byte.

A display ignores its inputs for some time after each write while it works internally. After the enable pulse the block therefore stays busy for a fixed number of clock cycles. It uses one wait for data bytes and a separate, usually longer one for commands, because some commands such as clearing the screen take longer. The read/write line is always held at the write level. All pulse widths and waits are parameters counted in clock cycles, and each must be at least 1.

Top module: `lcd_write_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `ready` is 1, `lcd_en` is 0 and `lcd_rw` is 0.
- R2: A start request seen at a rising clock edge while `ready` is 1 is accepted. `ready` is 0 from the cycle after that edge until the transfer's wait has expired.
- R3: From the cycle after acceptance, `lcd_db` equals the accepted byte and `lcd_rs` equals the accepted flag, where flag 0 means command and flag 1 means data.
- R4: `lcd_rw` is 0 in every cycle, because 0 selects a write.
- R5: `lcd_en` rises exactly `SETUP_CYC` cycles after the accepting edge.
- R6: `lcd_en` stays high for exactly `EN_HIGH_CYC` cycles and pulses once per transfer.
- R7: `lcd_db` and `lcd_rs` do not change while `lcd_en` is high or in the cycle after it falls. They keep their value until the next accepted request.
- R8: After `lcd_en` falls, `ready` returns to 1 after `DATA_WAIT_CYC` cycles for a data byte and after `CMD_WAIT_CYC` cycles for a command. The whole transfer keeps `ready` low for SETUP_CYC+EN_HIGH_CYC+wait cycles.
- R9: A start request while `ready` is 0 is ignored. It changes neither the bus, nor the select line, nor the timing of the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Transfer request, taken only while ready |
| is_data | input | 1 | 1 for a character byte, 0 for a command |
| byte_in | input | 8 | Byte to write |
| ready | output | 1 | Block can accept a request |
| lcd_db | output | 8 | Display data bus |
| lcd_rs | output | 1 | Register select: 0 command, 1 data |
| lcd_rw | output | 1 | Read/write, held at 0 (write) |
| lcd_en | output | 1 | Enable strobe, byte taken on its falling edge |

## Verification
Commands and data bytes are mixed in random order. This separates the two wait lengths and confirms that the select line follows the flag. Some transfers keep start high throughout the busy time, with a different byte and the opposite flag on the inputs. A design that restarts, or that re-latches the inputs while busy, then shows a shifted enable pulse or a changed bus. Back-to-back requests that arrive in the first ready cycle, and requests after idle gaps, check that a new request is taken exactly when the wait ends and not one cycle early. Every cycle of each transfer is compared against the expected enable, ready and bus levels, so any error in setup, pulse width or wait count by a single cycle is reported.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;
    localparam int unsigned BUS_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_BUSY
    } phase_e;

    typedef struct packed {
        logic             sel_data;
        logic [BUS_W-1:0] code;
    } xfer_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned top);
        return (top < 2) ? 1 : $clog2(top + 1);
    endfunction
endpackage

// File: rtl/lcd_wr_timer.sv
module lcd_wr_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/lcd_wr_seq.sv
module lcd_wr_seq
    import lcd_wr_pkg::*;
#(
    parameter int unsigned CNT_W         = 4,
    parameter int unsigned SETUP_CYC     = 2,
    parameter int unsigned EN_HIGH_CYC   = 3,
    parameter int unsigned DATA_WAIT_CYC = 6,
    parameter int unsigned CMD_WAIT_CYC  = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             held_data,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             capture,
    output phase_e           phase
);
    phase_e phase_nx;

    always_comb begin
        phase_nx = phase;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        unique case (phase)
            PH_IDLE: if (start) begin
                capture  = 1'b1;
                load     = 1'b1;
                load_val = CNT_W'(SETUP_CYC - 1);
                phase_nx = PH_SETUP;
            end
            PH_SETUP: if (expired) begin
                load     = 1'b1;
                load_val = CNT_W'(EN_HIGH_CYC - 1);
                phase_nx = PH_STROBE;
            end
            PH_STROBE: if (expired) begin
                load     = 1'b1;
                load_val = held_data ? CNT_W'(DATA_WAIT_CYC - 1)
                                     : CNT_W'(CMD_WAIT_CYC - 1);
                phase_nx = PH_BUSY;
            end
            PH_BUSY: if (expired) phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nx;
    end

    // a new transfer only starts from the idle phase
    assert_capture_idle_R2: assert property (@(posedge clk) disable iff (rst)
        capture |=> (phase == PH_SETUP));
endmodule

// File: rtl/lcd_wr_bus.sv
module lcd_wr_bus
    import lcd_wr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  xfer_t            req,
    output xfer_t            held
);
    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (capture)
            held <= req;
    end
endmodule

// File: rtl/lcd_write_ctrl.sv
module lcd_write_ctrl
    import lcd_wr_pkg::*;
#(
    parameter int unsigned SETUP_CYC     = 2,
    parameter int unsigned EN_HIGH_CYC   = 3,
    parameter int unsigned DATA_WAIT_CYC = 6,
    parameter int unsigned CMD_WAIT_CYC  = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_data,
    input  logic [BUS_W-1:0] byte_in,
    output logic             ready,
    output logic [BUS_W-1:0] lcd_db,
    output logic             lcd_rs,
    output logic             lcd_rw,
    output logic             lcd_en
);
    localparam int unsigned MAX_CNT = max_of(max_of(SETUP_CYC, EN_HIGH_CYC),
                                             max_of(DATA_WAIT_CYC, CMD_WAIT_CYC));
    localparam int unsigned CNT_W   = cnt_width(MAX_CNT);

    logic             load;
    logic             capture;
    logic             expired;
    logic [CNT_W-1:0] load_val;
    phase_e           phase;
    xfer_t            req;
    xfer_t            held;

    assign req.sel_data = is_data;
    assign req.code     = byte_in;

    lcd_wr_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    lcd_wr_seq #(
        .CNT_W         (CNT_W),
        .SETUP_CYC     (SETUP_CYC),
        .EN_HIGH_CYC   (EN_HIGH_CYC),
        .DATA_WAIT_CYC (DATA_WAIT_CYC),
        .CMD_WAIT_CYC  (CMD_WAIT_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .held_data (held.sel_data),
        .expired   (expired),
        .load      (load),
        .load_val  (load_val),
        .capture   (capture),
        .phase     (phase)
    );

    lcd_wr_bus u_bus (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .req     (req),
        .held    (held)
    );

    assign ready  = (phase == PH_IDLE);
    assign lcd_en = (phase == PH_STROBE);
    assign lcd_db = held.code;
    assign lcd_rs = held.sel_data;
    assign lcd_rw = 1'b0;

    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
        (start && ready) |=> !ready);

    assert_busy_during_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        lcd_en |-> !ready);

    assert_setup_before_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_en) |-> ($stable(lcd_db) && $stable(lcd_rs)));

    assert_hold_after_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        lcd_en |=> ($stable(lcd_db) && $stable(lcd_rs)));

    assert_ignore_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !ready) |=> ($stable(lcd_db) && $stable(lcd_rs)));
endmodule

// File: tb/lcd_write_ctrl_bench.sv
module lcd_write_ctrl_bench;
    localparam int unsigned S  = 2;
    localparam int unsigned E  = 3;
    localparam int unsigned DW = 6;
    localparam int unsigned CW = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       is_data = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       ready;
    logic [7:0] lcd_db;
    logic       lcd_rs;
    logic       lcd_rw;
    logic       lcd_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lcd_write_ctrl #(
        .SETUP_CYC(S), .EN_HIGH_CYC(E), .DATA_WAIT_CYC(DW), .CMD_WAIT_CYC(CW)
    ) u_lcd_write_ctrl (
        .clk(clk), .rst(rst), .start(start), .is_data(is_data), .byte_in(byte_in),
        .ready(ready), .lcd_db(lcd_db), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int unsigned wait_for(input bit dat);
        return dat ? DW : CW;
    endfunction

    function automatic bit exp_en(input int k);
        return (k >= int'(S)) && (k < int'(S + E));
    endfunction

    // one transfer; pester keeps start high with other inputs while busy
    task automatic xfer(input logic [7:0] b, input bit dat, input bit pester);
        int t;
        t = int'(S + E + wait_for(dat));
        chk("R2 ready before request", int'(ready), 1);
        start   = 1'b1;
        byte_in = b;
        is_data = dat;
        @(posedge clk);
        @(negedge clk);
        if (pester) begin
            byte_in = ~b;
            is_data = ~dat;
        end else begin
            start = 1'b0;
        end
        for (int k = 0; k <= t; k++) begin
            chk("R5/R6 enable timing", int'(lcd_en), int'(exp_en(k)));
            chk("R2/R8 ready timing", int'(ready), int'(k >= t));
            chk("R3/R7/R9 bus byte", int'(lcd_db), int'(b));
            chk("R3/R9 select line", int'(lcd_rs), int'(dat));
            chk("R4 write level", int'(lcd_rw), 0);
            if (k == t) begin
                start = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", int'(ready), 1);
        chk("R1 enable in reset", int'(lcd_en), 0);
        chk("R1 rw in reset", int'(lcd_rw), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", int'(ready), 1);
        chk("R1 enable after reset", int'(lcd_en), 0);

        // directed: command, data, back-to-back, pestered
        xfer(8'h01, 1'b0, 1'b0);
        @(negedge clk);
        xfer(8'h41, 1'b1, 1'b0);
        xfer(8'h42, 1'b1, 1'b1);
        xfer(8'h80, 1'b0, 1'b1);
        @(negedge clk);
        chk("R7 bus kept when idle", int'(lcd_db), 8'h80);

        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [7:0] b;
            bit d, p;
            int gap;
            b   = 8'($urandom);
            d   = 1'($urandom);
            p   = 1'($urandom);
            gap = int'($urandom % 4);
            for (int g = 0; g < gap; g++) @(negedge clk);
            xfer(b, d, p);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule